// File: doc/BRIEF.md
# Debug Instruction Injection Buffer

This block holds one machine instruction, up to a parameterised number of bytes (five by default), that a debug host places in front of a halted CPU. The host reaches the buffer through a write-only register window. It loads an address pointer, then streams data bytes. With auto-increment on, the pointer steps by one after each byte. The CPU side sees a halted flag, a one-clock execute pulse, and a byte fetch port that hands out the stored bytes in order.

Byte 0 is the first byte the CPU fetches. In the default descending map it sits at the top address of the window. An ascending burst that starts at the window base therefore loads the operand bytes first and byte 0 last. Writing byte 0 while the CPU is halted releases it to run exactly one instruction. The CPU fetches only the bytes it needs and reports completion. The buffer then halts the CPU again and rewinds its fetch pointer. A fetch beyond the last stored byte returns zero and raises a sticky error flag.

Top module: `dbg_inject_buf`

## Requirements
- R1: After reset `halted` is 1, `exec_go` and `fetch_err` are 0, every stored byte is 0, and the fetch pointer selects byte 0, so `fetch_data` reads 0x00.
- R2: With the descending map, store byte k is written at address BASE_ADDR + (NUM_BYTES-1-k), so byte 0 sits at BASE_ADDR+4 by default. A write to an address outside BASE_ADDR..BASE_ADDR+NUM_BYTES-1 changes no stored byte.
- R3: `host_ld` loads `host_addr` into the write pointer. A write with `host_inc`=1 advances the pointer by one after the byte. A write with `host_inc`=0 leaves the pointer where it is, so a second write lands on the same byte.
- R4: A write to byte 0 while `halted`=1 raises `exec_go` for exactly one clock, starting at the clock edge that stores the byte. At that same edge `halted` drops to 0 and `fetch_err` clears.
- R5: A write to byte 0 while `halted`=0 stores the data but produces no `exec_go` pulse.
- R6: Writes to bytes 1 to NUM_BYTES-1 never produce `exec_go` and never change `halted`.
- R7: While running, `fetch_data` shows byte 0 first. Each `cpu_fetch` clock moves to the next byte in the order 0, 1, 2, 3, 4.
- R8: Once all NUM_BYTES bytes have been fetched, `fetch_data` is 0x00. A further `cpu_fetch` sets `fetch_err` at that edge, and the flag stays set until the next `exec_go`.
- R9: `cpu_done` while running sets `halted` at that edge and returns the fetch pointer to byte 0.
- R10: `cpu_fetch` while `halted`=1 is ignored: the fetch pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ld | input | 1 | Load the write pointer from `host_addr` |
| host_addr | input | ADDR_W | Address value for a pointer load |
| host_wr | input | 1 | Write `host_data` at the write pointer |
| host_data | input | DATA_W | Data byte from the debug host |
| host_inc | input | 1 | Advance the write pointer after this write |
| cpu_fetch | input | 1 | CPU consumes the byte now on `fetch_data` |
| cpu_done | input | 1 | Injected instruction has completed |
| fetch_data | output | DATA_W | Byte at the fetch pointer, or 0 past the end |
| halted | output | 1 | CPU is held in the debug halted state |
| exec_go | output | 1 | One-clock release pulse for a single instruction |
| fetch_err | output | 1 | Sticky flag set by a fetch past the last byte |

## Verification
The bench builds the block with the default width, depth and descending map, and moves BASE_ADDR to 0x10. With that base, addresses on both sides of the window (0x0F and 0x15) can be written to show that nothing outside the window lands in the store. Bursts from the base reach byte 0 only on their fifth write. This makes it visible that the pulse waits for the last byte. It also exercises the full five-byte fetch run up to the overflow fetch.

// File: rtl/dbg_inj_pkg.sv
package dbg_inj_pkg;
   localparam int MAX_BYTES = 16;

   function automatic int fetch_idx_w(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/dbg_inj_addr_ctrl.sv
module dbg_inj_addr_ctrl #(
   parameter int ADDR_W      = 8,
   parameter int NUM_BYTES   = 5,
   parameter int BASE_ADDR   = 16,
   parameter bit DESCEND_MAP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_ld,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic                 host_wr,
   input  logic                 host_inc,
   output logic [NUM_BYTES-1:0] wr_sel
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] off;
   logic              in_win;

   always_ff @(posedge clk) begin
      if (!rst_n)                   ptr <= '0;
      else if (host_ld)             ptr <= host_addr;
      else if (host_wr && host_inc) ptr <= ptr + 1'b1;
   end

   assign off    = ptr - BASE;
   assign in_win = off < ADDR_W'(NUM_BYTES);

   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_dec
      localparam int SLOT = DESCEND_MAP ? (NUM_BYTES - 1 - k) : k;
      assign wr_sel[k] = host_wr && in_win && (off == ADDR_W'(SLOT));
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel)); // R2
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_inc && !host_ld) |=> $stable(ptr)); // R3
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_inc && !host_ld) |=> ptr == $past(ptr) + 1'b1); // R3
endmodule

// File: rtl/dbg_inj_store.sv
module dbg_inj_store #(
   parameter int DATA_W    = 8,
   parameter int NUM_BYTES = 5,
   parameter int IDX_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BYTES-1:0] wr_sel,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [DATA_W-1:0]    rd_data
);
   logic [NUM_BYTES-1:0][DATA_W-1:0] bytes_q;

   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)         bytes_q[k] <= '0;
         else if (wr_sel[k]) bytes_q[k] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_BYTES; i++)
         if (rd_idx == IDX_W'(i)) rd_data = bytes_q[i];
   end

   AST_RD_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx >= IDX_W'(NUM_BYTES)) |-> (rd_data == '0)); // R8
endmodule

// File: rtl/dbg_inj_seq.sv
module dbg_inj_seq #(
   parameter int NUM_BYTES = 5,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             cpu_fetch,
   input  logic             cpu_done,
   output logic             halted,
   output logic             exec_go,
   output logic             fetch_err,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BYTES);

   logic fire;
   assign fire = trig && halted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted    <= 1'b1;
         exec_go   <= 1'b0;
         fetch_err <= 1'b0;
         idx       <= '0;
      end else begin
         exec_go <= fire;
         if (fire) begin
            halted    <= 1'b0;
            fetch_err <= 1'b0;
         end else if (!halted && cpu_done) begin
            halted <= 1'b1;
            idx    <= '0;
         end else if (!halted && cpu_fetch) begin
            if (idx < LAST) idx <= idx + 1'b1;
            else            fetch_err <= 1'b1;
         end
      end
   end

   AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_go |=> !exec_go); // R4
   AST_EXEC_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      exec_go |-> !halted && !fetch_err); // R4
   AST_NO_RUN_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !halted) |=> !exec_go); // R5
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST); // R8
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_err) |-> ($past(idx) == LAST && $past(cpu_fetch))); // R8
   AST_DONE_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !halted) |=> (halted && idx == '0)); // R9
   AST_HALT_FETCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && cpu_fetch) |=> $stable(idx)); // R10
endmodule

// File: rtl/dbg_inject_buf.sv
module dbg_inject_buf
   import dbg_inj_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int NUM_BYTES   = 5,
   parameter int BASE_ADDR   = 48,
   parameter bit DESCEND_MAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_ld,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              host_inc,
   input  logic              cpu_fetch,
   input  logic              cpu_done,
   output logic [DATA_W-1:0] fetch_data,
   output logic              halted,
   output logic              exec_go,
   output logic              fetch_err
);
   localparam int IDX_W = fetch_idx_w(NUM_BYTES);

   if (NUM_BYTES < 1 || NUM_BYTES > MAX_BYTES) begin : g_bad_depth
      $error("dbg_inject_buf: NUM_BYTES out of range");
   end
   if (BASE_ADDR < 0 || BASE_ADDR + NUM_BYTES > (1 << ADDR_W)) begin : g_bad_base
      $error("dbg_inject_buf: register window exceeds address space");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dbg_inject_buf: DATA_W must be positive");
   end

   logic [NUM_BYTES-1:0] wr_sel;
   logic [IDX_W-1:0]     idx;

   dbg_inj_addr_ctrl #(
      .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES),
      .BASE_ADDR(BASE_ADDR), .DESCEND_MAP(DESCEND_MAP)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .host_ld(host_ld), .host_addr(host_addr),
      .host_wr(host_wr), .host_inc(host_inc), .wr_sel(wr_sel)
   );

   dbg_inj_store #(
      .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(host_data),
      .rd_idx(idx), .rd_data(fetch_data)
   );

   dbg_inj_seq #(
      .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .trig(wr_sel[0]), .cpu_fetch(cpu_fetch),
      .cpu_done(cpu_done), .halted(halted), .exec_go(exec_go),
      .fetch_err(fetch_err), .idx(idx)
   );

   AST_SECONDARY_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_sel[0] && halted) |=> (halted && !exec_go)); // R6
endmodule

// File: tb/dbg_inject_buf_tb.sv
module dbg_inject_buf_tb;
   localparam int BASE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_ld = 0, host_wr = 0, host_inc = 0, cpu_fetch = 0, cpu_done = 0;
   logic [7:0] host_addr = '0, host_data = '0;
   logic [7:0] fetch_data;
   logic       halted, exec_go, fetch_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dbg_inject_buf #(.BASE_ADDR(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_ld(host_ld), .host_addr(host_addr),
      .host_wr(host_wr), .host_data(host_data), .host_inc(host_inc),
      .cpu_fetch(cpu_fetch), .cpu_done(cpu_done), .fetch_data(fetch_data),
      .halted(halted), .exec_go(exec_go), .fetch_err(fetch_err)
   );

   // {byte4..byte0, fetch length}
   localparam logic [47:0] VEC [4] = '{
      {40'h44_33_22_11_A5, 8'd1},
      {40'h0F_1E_2D_3C_4B, 8'd3},
      {40'hFF_00_80_7F_01, 8'd5},
      {40'h12_34_56_78_9A, 8'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load_addr(input logic [7:0] a);
      host_ld = 1; host_addr = a;
      @(negedge clk);
      host_ld = 0;
   endtask

   task automatic wr_byte(input logic [7:0] d, input logic inc);
      host_wr = 1; host_data = d; host_inc = inc;
      @(negedge clk);
      host_wr = 0; host_inc = 0;
   endtask

   task automatic fetch_one();
      cpu_fetch = 1;
      @(negedge clk);
      cpu_fetch = 0;
   endtask

   task automatic finish_instr();
      cpu_done = 1;
      @(negedge clk);
      cpu_done = 0;
   endtask

   task automatic burst(input logic [39:0] b);
      load_addr(8'(BASE));
      for (int i = 4; i >= 0; i--) begin
         wr_byte(b[8*i +: 8], 1'b1);
         if (i > 0) chk("R6 no pulse on operand byte", exec_go, 0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 halted", halted, 1);
      chk("R1 exec_go", exec_go, 0);
      chk("R1 fetch_err", fetch_err, 0);
      chk("R1 fetch_data", fetch_data, 0);

      // Table walk: burst load, trigger, fetch, complete
      for (int v = 0; v < 4; v++) begin
         logic [39:0] b;
         int          n;
         b = VEC[v][47:8];
         n = int'(VEC[v][7:0]);
         burst(b);
         chk("R4 pulse on byte0 write", exec_go, 1);
         chk("R4 halted clears", halted, 0);
         @(negedge clk);
         chk("R4 pulse is one clock", exec_go, 0);
         for (int j = 0; j < n; j++) begin
            chk("R7 fetch order", fetch_data, 32'(b[8*j +: 8]));
            chk("R2 descending map", fetch_data, 32'(b[8*j +: 8]));
            fetch_one();
         end
         finish_instr();
         chk("R9 halted after done", halted, 1);
         chk("R9 pointer rewound", fetch_data, 32'(b[7:0]));
      end

      // R10: fetch while halted ignored (byte0 currently 0x9A)
      fetch_one();
      fetch_one();
      chk("R10 halted fetch ignored", fetch_data, 32'h9A);

      // R3: no-increment writes overwrite the same byte (byte4)
      load_addr(8'(BASE));
      wr_byte(8'hC1, 1'b0);
      wr_byte(8'hC2, 1'b0);
      // R2: out-of-window writes
      load_addr(8'(BASE - 1));
      wr_byte(8'hEE, 1'b1);
      load_addr(8'(BASE + 5));
      wr_byte(8'hEE, 1'b0);
      chk("R6 halted kept", halted, 1);
      load_addr(8'(BASE + 4));
      wr_byte(8'h5A, 1'b0);
      chk("R4 trigger by address write", exec_go, 1);
      @(negedge clk);
      chk("R2 byte0", fetch_data, 32'h5A); fetch_one();
      chk("R2 byte1 untouched", fetch_data, 32'h78); fetch_one();
      chk("R2 byte2 untouched", fetch_data, 32'h56); fetch_one();
      chk("R2 byte3 untouched", fetch_data, 32'h34); fetch_one();
      chk("R3 byte4 holds second write", fetch_data, 32'hC2); fetch_one();

      // R8: sixth fetch
      chk("R8 past-end data", fetch_data, 0);
      chk("R8 err not yet", fetch_err, 0);
      fetch_one();
      chk("R8 err set", fetch_err, 1);
      chk("R8 data still zero", fetch_data, 0);
      fetch_one();
      chk("R8 err sticky", fetch_err, 1);

      // R5: byte0 write while running -> stored, no pulse
      load_addr(8'(BASE + 4));
      wr_byte(8'h77, 1'b0);
      chk("R5 no pulse while running", exec_go, 0);
      @(negedge clk);
      chk("R5 no pulse later", exec_go, 0);
      chk("R5 still running", halted, 0);
      finish_instr();
      chk("R5 byte0 stored", fetch_data, 32'h77);
      chk("R8 err survives done", fetch_err, 1);
      load_addr(8'(BASE + 4));
      wr_byte(8'h66, 1'b0);
      chk("R4 pulse", exec_go, 1);
      chk("R4 err cleared on pulse", fetch_err, 0);
      finish_instr();
      chk("R9 halted again", halted, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule